// File: doc/BRIEF.md
# Main and ALU Control Decoder

This block turns the opcode and function fields of a 32-bit RISC instruction into the steering signals of a single-cycle datapath. It is purely combinational. One path gives ten control bits from the instruction class: destination select, register write, extension type, second-operand select, memory read, memory write, writeback source, the two conditional branch flags and the jump flag. A second path gives the 4-bit ALU control word. For register-register instructions that word comes from the function field. For every other instruction it comes from the opcode.

The supported set has these parts:
- Register-register: add, sub, and, or, xor, slt.
- Immediate arithmetic and logic: addi, slti, andi, ori, xori.
- Load word and store word.
- Branch on equal, branch on not equal, and jump.

Any other opcode produces all-zero outputs. A register-register opcode with an unlisted function code also produces all-zero outputs. Each control bit is a reduced function of the decoded class, not a full truth table. For example, sign extension is off only for the three logical immediates, so a jump or branch still shows it set.

Top module: `ctl_decoder`

## Requirements
- R1: With opcode 0x00, the function codes 0x20, 0x22, 0x24, 0x25, 0x26 and 0x2A give the ALU words below. The word is {result select[1:0], sub-op[1:0]}. Result select is 01 for set-less-than, 10 for arithmetic and 11 for logic. Arithmetic sub-ops are 00 add and 01 subtract. Logic sub-ops are 00 and, 01 or and 11 xor.

  | Function code | Operation | ALU word |
  |---|---|---|
  | 0x20 | add | 1000 |
  | 0x22 | sub | 1001 |
  | 0x24 | and | 1100 |
  | 0x25 | or | 1101 |
  | 0x26 | xor | 1111 |
  | 0x2A | slt | 0101 |

- R2: For a supported register-register instruction the outputs are:
  - destination select = 1, register write = 1, sign extension = 1;
  - operand select = 0;
  - memory read, memory write, writeback source, both branch flags and jump = 0.
- R3: The immediate opcodes all give register write = 1, operand select = 1 and destination select = 0. Their other outputs are:

  | Instruction | Opcode | ALU word | Sign extension |
  |---|---|---|---|
  | addi | 0x08 | 1000 | 1 |
  | slti | 0x0A | 0101 | 1 |
  | andi | 0x0C | 1100 | 0 |
  | ori | 0x0D | 1101 | 0 |
  | xori | 0x0E | 1111 | 0 |

- R4: Load (0x23) gives register write = 1, sign extension = 1, operand select = 1, memory read = 1, writeback source = 1, memory write = 0 and ALU word 1000.
- R5: Store (0x2B) gives memory write = 1, register write = 0, sign extension = 1, operand select = 1, memory read = 0 and ALU word 1000.
- R6: Branch on equal (0x04) raises only the equal-branch flag, and branch on not equal (0x05) raises only the not-equal flag. Both give operand select = 0, register write = 0, sign extension = 1 and ALU word 1001 (subtract).
- R7: Jump (0x02) raises the jump flag. It gives register write = 0, memory read = 0, memory write = 0, sign extension = 1, operand select = 1 and ALU word 1000.
- R8: Every opcode outside the eleven listed (0x00, 0x02, 0x04, 0x05, 0x08, 0x0A, 0x0C, 0x0D, 0x0E, 0x23, 0x2B) drives all ten controls and the ALU word to zero.
- R9: Opcode 0x00 with a function code outside the six listed drives all ten controls and the ALU word to zero.
- R10: For any opcode other than 0x00, the function field has no effect on any output.
- R11: At most one of memory read, memory write, equal-branch, not-equal-branch and jump is 1 at any time. Writeback source always equals memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Opcode field of the instruction |
| funct_i | input | 6 | Function field of the instruction |
| reg_dst_o | output | 1 | 1: write the Rd field register, 0: the Rt field register |
| reg_wr_o | output | 1 | Register file write enable |
| ext_sign_o | output | 1 | 1: sign-extend the 16-bit immediate, 0: zero-extend |
| alu_src_imm_o | output | 1 | 1: second ALU operand is the immediate, 0: second register |
| mem_rd_o | output | 1 | Data memory read enable |
| mem_wr_o | output | 1 | Data memory write enable |
| mem_to_reg_o | output | 1 | 1: write back memory data, 0: ALU result |
| br_eq_o | output | 1 | Branch-if-equal instruction |
| br_ne_o | output | 1 | Branch-if-not-equal instruction |
| jmp_o | output | 1 | Jump instruction |
| alu_ctrl_o | output | 4 | ALU control word {result select, sub-op} |

## Verification
The opcode-driven main control and the function-driven ALU control are produced in the same evaluation. They can contradict each other when a register-register opcode carries an unknown function code. The bench provokes this by sweeping every unlisted function code under opcode 0x00. It judges each one by requiring that both paths go to zero together, so no register write can pair with a stale ALU word. The opposite overlap is also checked: listed function codes placed under immediate, load and branch opcodes must leave both paths at their opcode-only values.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int SEL_W = 2;
    localparam int SUB_W = 2;
    localparam int ALU_W = SEL_W + SUB_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_SHIFT = 2'b00,
        SEL_SLT   = 2'b01,
        SEL_ARITH = 2'b10,
        SEL_LOGIC = 2'b11
    } res_sel_e;

    localparam logic [SUB_W-1:0] SUB_ADD = 2'b00;
    localparam logic [SUB_W-1:0] SUB_SUB = 2'b01;
    localparam logic [SUB_W-1:0] LOG_AND = 2'b00;
    localparam logic [SUB_W-1:0] LOG_OR  = 2'b01;
    localparam logic [SUB_W-1:0] LOG_XOR = 2'b11;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_BNE   = 6'h05;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OP_W-1:0] OPC_SLTI  = 6'h0A;
    localparam logic [OP_W-1:0] OPC_ANDI  = 6'h0C;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OP_W-1:0] OPC_XORI  = 6'h0E;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_XOR = 6'h26;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        CLS_NONE,
        CLS_RTYPE,
        CLS_ADDI,
        CLS_SLTI,
        CLS_ANDI,
        CLS_ORI,
        CLS_XORI,
        CLS_LOAD,
        CLS_STORE,
        CLS_BEQ,
        CLS_BNE,
        CLS_JUMP
    } insn_cls_e;

    typedef struct packed {
        logic reg_dst;
        logic reg_wr;
        logic ext_sign;
        logic alu_src_imm;
        logic mem_rd;
        logic mem_wr;
        logic mem_to_reg;
        logic br_eq;
        logic br_ne;
        logic jmp;
    } main_ctl_t;

    typedef struct packed {
        res_sel_e         sel;
        logic [SUB_W-1:0] sub;
    } alu_ctl_t;

    localparam alu_ctl_t ALU_IDLE = '{sel: SEL_SHIFT, sub: 2'b00};

    function automatic logic funct_known(input logic [FN_W-1:0] f);
        return (f == FN_ADD) || (f == FN_SUB) || (f == FN_AND) ||
               (f == FN_OR)  || (f == FN_XOR) || (f == FN_SLT);
    endfunction

    function automatic logic cls_logic_imm(input insn_cls_e c);
        return (c == CLS_ANDI) || (c == CLS_ORI) || (c == CLS_XORI);
    endfunction

endpackage

// File: rtl/ctl_dec_class.sv
module ctl_dec_class
    import ctl_dec_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [FN_W-1:0] funct_i,
    output insn_cls_e       cls_o
);
    always_comb begin
        unique case (op_i)
            OPC_RTYPE: cls_o = funct_known(funct_i) ? CLS_RTYPE : CLS_NONE;
            OPC_JUMP:  cls_o = CLS_JUMP;
            OPC_BEQ:   cls_o = CLS_BEQ;
            OPC_BNE:   cls_o = CLS_BNE;
            OPC_ADDI:  cls_o = CLS_ADDI;
            OPC_SLTI:  cls_o = CLS_SLTI;
            OPC_ANDI:  cls_o = CLS_ANDI;
            OPC_ORI:   cls_o = CLS_ORI;
            OPC_XORI:  cls_o = CLS_XORI;
            OPC_LOAD:  cls_o = CLS_LOAD;
            OPC_STORE: cls_o = CLS_STORE;
            default:   cls_o = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/ctl_dec_main.sv
module ctl_dec_main
    import ctl_dec_pkg::*;
(
    input  insn_cls_e cls_i,
    output main_ctl_t ctl_o
);
    logic supported;
    logic no_write;
    logic reg_operand;

    always_comb begin
        supported   = (cls_i != CLS_NONE);
        no_write    = (cls_i == CLS_STORE) || (cls_i == CLS_BEQ) ||
                      (cls_i == CLS_BNE)   || (cls_i == CLS_JUMP);
        reg_operand = (cls_i == CLS_RTYPE) || (cls_i == CLS_BEQ) ||
                      (cls_i == CLS_BNE);

        ctl_o.reg_dst     = (cls_i == CLS_RTYPE);
        ctl_o.reg_wr      = supported && !no_write;
        ctl_o.ext_sign    = supported && !cls_logic_imm(cls_i);
        ctl_o.alu_src_imm = supported && !reg_operand;
        ctl_o.mem_rd      = (cls_i == CLS_LOAD);
        ctl_o.mem_to_reg  = (cls_i == CLS_LOAD);
        ctl_o.mem_wr      = (cls_i == CLS_STORE);
        ctl_o.br_eq       = (cls_i == CLS_BEQ);
        ctl_o.br_ne       = (cls_i == CLS_BNE);
        ctl_o.jmp         = (cls_i == CLS_JUMP);
    end
endmodule

// File: rtl/ctl_dec_alu.sv
module ctl_dec_alu
    import ctl_dec_pkg::*;
(
    input  insn_cls_e       cls_i,
    input  logic [FN_W-1:0] funct_i,
    output alu_ctl_t        alu_o
);
    alu_ctl_t from_funct;

    always_comb begin
        unique case (funct_i)
            FN_ADD:  from_funct = '{sel: SEL_ARITH, sub: SUB_ADD};
            FN_SUB:  from_funct = '{sel: SEL_ARITH, sub: SUB_SUB};
            FN_AND:  from_funct = '{sel: SEL_LOGIC, sub: LOG_AND};
            FN_OR:   from_funct = '{sel: SEL_LOGIC, sub: LOG_OR};
            FN_XOR:  from_funct = '{sel: SEL_LOGIC, sub: LOG_XOR};
            FN_SLT:  from_funct = '{sel: SEL_SLT,   sub: SUB_SUB};
            default: from_funct = ALU_IDLE;
        endcase
    end

    always_comb begin
        unique case (cls_i)
            CLS_NONE:          alu_o = ALU_IDLE;
            CLS_RTYPE:         alu_o = from_funct;
            CLS_BEQ, CLS_BNE:  alu_o = '{sel: SEL_ARITH, sub: SUB_SUB};
            CLS_SLTI:          alu_o = '{sel: SEL_SLT,   sub: SUB_SUB};
            CLS_ANDI:          alu_o = '{sel: SEL_LOGIC, sub: LOG_AND};
            CLS_ORI:           alu_o = '{sel: SEL_LOGIC, sub: LOG_OR};
            CLS_XORI:          alu_o = '{sel: SEL_LOGIC, sub: LOG_XOR};
            default:           alu_o = '{sel: SEL_ARITH, sub: SUB_ADD};
        endcase
    end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
    import ctl_dec_pkg::*;
(
    input  logic [OP_W-1:0]  op_i,
    input  logic [FN_W-1:0]  funct_i,
    output logic             reg_dst_o,
    output logic             reg_wr_o,
    output logic             ext_sign_o,
    output logic             alu_src_imm_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             mem_to_reg_o,
    output logic             br_eq_o,
    output logic             br_ne_o,
    output logic             jmp_o,
    output logic [ALU_W-1:0] alu_ctrl_o
);
    insn_cls_e cls;
    main_ctl_t main_ctl;
    alu_ctl_t  alu_ctl;

    ctl_dec_class u_class (
        .op_i    (op_i),
        .funct_i (funct_i),
        .cls_o   (cls)
    );

    ctl_dec_main u_main (
        .cls_i (cls),
        .ctl_o (main_ctl)
    );

    ctl_dec_alu u_alu (
        .cls_i   (cls),
        .funct_i (funct_i),
        .alu_o   (alu_ctl)
    );

    assign reg_dst_o     = main_ctl.reg_dst;
    assign reg_wr_o      = main_ctl.reg_wr;
    assign ext_sign_o    = main_ctl.ext_sign;
    assign alu_src_imm_o = main_ctl.alu_src_imm;
    assign mem_rd_o      = main_ctl.mem_rd;
    assign mem_wr_o      = main_ctl.mem_wr;
    assign mem_to_reg_o  = main_ctl.mem_to_reg;
    assign br_eq_o       = main_ctl.br_eq;
    assign br_ne_o       = main_ctl.br_ne;
    assign jmp_o         = main_ctl.jmp;
    assign alu_ctrl_o    = alu_ctl;
endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk
    import ctl_dec_pkg::*;
(
    input logic [OP_W-1:0]  op_i,
    input logic             reg_dst_o,
    input logic             reg_wr_o,
    input logic             alu_src_imm_o,
    input logic             ext_sign_o,
    input logic             mem_rd_o,
    input logic             mem_wr_o,
    input logic             mem_to_reg_o,
    input logic             br_eq_o,
    input logic             br_ne_o,
    input logic             jmp_o,
    input logic [ALU_W-1:0] alu_ctrl_o
);
    logic op_listed;

    always_comb begin
        op_listed = (op_i == OPC_RTYPE) || (op_i == OPC_JUMP) ||
                    (op_i == OPC_BEQ)   || (op_i == OPC_BNE)  ||
                    (op_i == OPC_ADDI)  || (op_i == OPC_SLTI) ||
                    (op_i == OPC_ANDI)  || (op_i == OPC_ORI)  ||
                    (op_i == OPC_XORI)  || (op_i == OPC_LOAD) ||
                    (op_i == OPC_STORE);

        // R11: memory and control-flow actions exclude each other
        assert_action_onehot_R11: assert ($onehot0({mem_rd_o, mem_wr_o, br_eq_o, br_ne_o, jmp_o}));
        // R4: writeback source follows memory read
        assert_wb_follows_rd_R4: assert (mem_to_reg_o == mem_rd_o);
        // R5: a store never writes the register file
        assert_store_no_regwr_R5: assert (!mem_wr_o || (!reg_wr_o && alu_src_imm_o));
        // R2: Rd destination always pairs with a register second operand
        assert_rd_uses_reg_R2: assert (!reg_dst_o || (!alu_src_imm_o && reg_wr_o));
        // R6: branches compute with subtract
        assert_branch_sub_R6: assert (!(br_eq_o || br_ne_o) || alu_ctrl_o == 4'b1001);
        // R3: zero-extended writes are logic operations
        assert_zext_logic_R3: assert (!(reg_wr_o && !ext_sign_o) || alu_ctrl_o[3:2] == 2'b11);
        // R8: unlisted opcodes give quiet outputs
        assert_unlisted_quiet_R8: assert (op_listed ||
            ({reg_dst_o, reg_wr_o, ext_sign_o, alu_src_imm_o, mem_rd_o, mem_wr_o,
              mem_to_reg_o, br_eq_o, br_ne_o, jmp_o} == '0 && alu_ctrl_o == '0));
    end
endmodule

bind ctl_decoder ctl_decoder_chk u_chk (
    .op_i          (op_i),
    .reg_dst_o     (reg_dst_o),
    .reg_wr_o      (reg_wr_o),
    .alu_src_imm_o (alu_src_imm_o),
    .ext_sign_o    (ext_sign_o),
    .mem_rd_o      (mem_rd_o),
    .mem_wr_o      (mem_wr_o),
    .mem_to_reg_o  (mem_to_reg_o),
    .br_eq_o       (br_eq_o),
    .br_ne_o       (br_ne_o),
    .jmp_o         (jmp_o),
    .alu_ctrl_o    (alu_ctrl_o)
);

// File: tb/ctl_decoder_tb.sv
`timescale 1ns/1ps
module ctl_decoder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] op_i = '0;
    logic [5:0] funct_i = '0;
    logic reg_dst_o, reg_wr_o, ext_sign_o, alu_src_imm_o, mem_rd_o, mem_wr_o;
    logic mem_to_reg_o, br_eq_o, br_ne_o, jmp_o;
    logic [3:0] alu_ctrl_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [13:0] exp_q[$];
    string       tag_q[$];
    logic [13:0] exp_cur;
    logic [13:0] got_cur;
    string       tag_cur;

    always #5 clk = ~clk;

    ctl_decoder u_dut (
        .op_i(op_i), .funct_i(funct_i),
        .reg_dst_o(reg_dst_o), .reg_wr_o(reg_wr_o), .ext_sign_o(ext_sign_o),
        .alu_src_imm_o(alu_src_imm_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_to_reg_o(mem_to_reg_o), .br_eq_o(br_eq_o), .br_ne_o(br_ne_o),
        .jmp_o(jmp_o), .alu_ctrl_o(alu_ctrl_o)
    );

    // expected main bits order: dst wr ext src mrd mwr m2r beq bne jmp
    task automatic apply(input logic [5:0] op, input logic [5:0] fn,
                         input logic [9:0] em, input logic [3:0] ea, input string tag);
        @(posedge clk);
        #1;
        op_i    = op;
        funct_i = fn;
        exp_q.push_back({em, ea});
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_cur = exp_q.pop_front();
            tag_cur = tag_q.pop_front();
            got_cur = {reg_dst_o, reg_wr_o, ext_sign_o, alu_src_imm_o, mem_rd_o,
                       mem_wr_o, mem_to_reg_o, br_eq_o, br_ne_o, jmp_o, alu_ctrl_o};
            n_vec++;
            if (got_cur !== exp_cur) begin
                n_bad++;
                $display("FAIL %s op=%h funct=%h actual=%b expected=%b",
                         tag_cur, op_i, funct_i, got_cur, exp_cur);
            end
        end
    end

    function automatic bit op_listed(input int k);
        return k == 'h00 || k == 'h02 || k == 'h04 || k == 'h05 || k == 'h08 ||
               k == 'h0A || k == 'h0C || k == 'h0D || k == 'h0E || k == 'h23 || k == 'h2B;
    endfunction

    function automatic bit fn_listed(input int k);
        return k == 'h20 || k == 'h22 || k == 'h24 || k == 'h25 || k == 'h26 || k == 'h2A;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R9: idle inputs (R-type, funct 0) give quiet outputs
        apply(6'h00, 6'h00, 10'b0000000000, 4'b0000, "R9 idle");
        // R1 / R2: register-register
        apply(6'h00, 6'h20, 10'b1110000000, 4'b1000, "R1 R2 add");
        apply(6'h00, 6'h22, 10'b1110000000, 4'b1001, "R1 R2 sub");
        apply(6'h00, 6'h24, 10'b1110000000, 4'b1100, "R1 R2 and");
        apply(6'h00, 6'h25, 10'b1110000000, 4'b1101, "R1 R2 or");
        apply(6'h00, 6'h26, 10'b1110000000, 4'b1111, "R1 R2 xor");
        apply(6'h00, 6'h2A, 10'b1110000000, 4'b0101, "R1 R2 slt");
        // R3: immediates
        apply(6'h08, 6'h00, 10'b0111000000, 4'b1000, "R3 addi");
        apply(6'h0A, 6'h00, 10'b0111000000, 4'b0101, "R3 slti");
        apply(6'h0C, 6'h00, 10'b0101000000, 4'b1100, "R3 andi");
        apply(6'h0D, 6'h00, 10'b0101000000, 4'b1101, "R3 ori");
        apply(6'h0E, 6'h00, 10'b0101000000, 4'b1111, "R3 xori");
        // R4 / R5
        apply(6'h23, 6'h00, 10'b0111101000, 4'b1000, "R4 lw");
        apply(6'h2B, 6'h00, 10'b0011010000, 4'b1000, "R5 sw");
        // R6 / R7
        apply(6'h04, 6'h00, 10'b0010000100, 4'b1001, "R6 beq");
        apply(6'h05, 6'h00, 10'b0010000010, 4'b1001, "R6 bne");
        apply(6'h02, 6'h00, 10'b0011000001, 4'b1000, "R7 j");
        // R10: funct ignored outside opcode 0x00
        apply(6'h08, 6'h22, 10'b0111000000, 4'b1000, "R10 addi+sub funct");
        apply(6'h0C, 6'h26, 10'b0101000000, 4'b1100, "R10 andi+xor funct");
        apply(6'h23, 6'h2A, 10'b0111101000, 4'b1000, "R10 lw+slt funct");
        apply(6'h04, 6'h20, 10'b0010000100, 4'b1001, "R10 beq+add funct");
        apply(6'h02, 6'h3F, 10'b0011000001, 4'b1000, "R10 j+ones funct");
        // R8: every unlisted opcode
        for (int k = 0; k < 64; k++)
            if (!op_listed(k))
                apply(k[5:0], 6'h20, 10'b0000000000, 4'b0000, "R8 unlisted opcode");
        // R9: every unlisted function code under opcode 0x00
        for (int k = 0; k < 64; k++)
            if (!fn_listed(k))
                apply(6'h00, k[5:0], 10'b0000000000, 4'b0000, "R9 unlisted funct");
        // R11: alternate memory and branch opcodes back to back
        apply(6'h23, 6'h00, 10'b0111101000, 4'b1000, "R11 lw");
        apply(6'h05, 6'h00, 10'b0010000010, 4'b1001, "R11 bne");
        apply(6'h2B, 6'h00, 10'b0011010000, 4'b1000, "R11 sw");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule